// File: doc/BRIEF.md
# Working Register File with Address Pointers

This block holds the thirty-two 8-bit working registers of a small 8-bit RISC core. Two combinational 8-bit read ports feed the execute stage. A 16-bit read port returns an aligned register pair. A single core write port stores either one byte or an aligned 16-bit word on a clock edge. Together these give the four operand shapes the core needs:
- one byte read with a byte result;
- two byte reads with a byte result;
- two byte reads with a word result written to a pair;
- a word read with a word result.

The six highest registers also act as three 16-bit address pointers. These are always present as outputs, so the address generator can use them without spending a read port.

The whole file is also mapped into the bottom of the data space. A load or store whose address falls in 0x00 to 0x1F is served by this block instead of memory. A hit flag tells the bus which source owns the read data. Reads always return the value stored before the current edge.

Top module: `gp_regfile`

## Requirements
- R1: After reset every register holds zero, and all read ports, pointer outputs and the data-space read data are zero.
- R2: `rdDataA` and `rdDataB` return the registers selected by `rdAddrA` and `rdAddrB` within the same cycle. There is no write-to-read bypass: during a write cycle the old value is returned.
- R3: With `wrMode` = 1 (byte), `wrData[7:0]` is stored into register `wrAddr` at the rising clock edge.
- R4: With `wrMode` = 2 (word), the pair is formed by clearing bit 0 of `wrAddr`. `wrData[7:0]` is stored into that even register and `wrData[15:8]` into the odd register above it, both on the same edge. `wrMode` values 0 and 3 write nothing.
- R5: `rdWord` equals {R[a|1], R[a&~1]}, where a is `rdAddrA`.
- R6: `ptrX` = {R27,R26}, `ptrY` = {R29,R28}, and `ptrZ` = {R31,R30}, each following the register contents continuously.
- R7: When `dsAddr` < 0x20, `dsHit` is 1 and `dsRdData` is R[`dsAddr`]. Otherwise `dsHit` is 0 and `dsRdData` is 0.
- R8: With `dsWrEn` high and `dsAddr` < 0x20, `dsWrData` is stored into R[`dsAddr`] at the edge. With any other address, no register changes.
- R9: When a core write and a data-space write target the same register in one cycle, the core value is stored. When they target different registers, both are stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| rdAddrA | input | 5 | Register select for read port A and the word read |
| rdAddrB | input | 5 | Register select for read port B |
| rdDataA | output | 8 | Contents of register rdAddrA |
| rdDataB | output | 8 | Contents of register rdAddrB |
| rdWord | output | 16 | Aligned pair containing rdAddrA |
| wrMode | input | 2 | 0 none, 1 byte, 2 word, 3 none |
| wrAddr | input | 5 | Core write register select |
| wrData | input | 16 | Core write value (byte mode uses bits 7:0) |
| dsAddr | input | 16 | Data-space address |
| dsWrEn | input | 1 | Data-space write strobe |
| dsWrData | input | 8 | Data-space write value |
| dsRdData | output | 8 | Data-space read value (zero when not a hit) |
| dsHit | output | 1 | Data-space address falls in the register window |
| ptrX | output | 16 | Pointer formed by R27:R26 |
| ptrY | output | 16 | Pointer formed by R29:R28 |
| ptrZ | output | 16 | Pointer formed by R31:R30 |

## Verification
The core write port and a store through the data-space window can land in the same cycle. This happens when a store hits the register window while the core retires a result. The bench provokes three cases:
- a byte write and a data-space write to the same register;
- a word write whose high byte collides with a data-space write;
- two writes to unrelated registers.

Each is judged by reading the file back through both the core port and the data-space port after the edge. The core value must survive a collision, and both values must land when the writes do not overlap.

// File: rtl/regfile_pkg.sv
package regfile_pkg;
  localparam int REG_COUNT = 32;
  localparam int BYTE_W    = 8;
  localparam int ADDR_W    = $clog2(REG_COUNT);

  typedef enum logic [1:0] {
    WR_NONE = 2'd0,
    WR_BYTE = 2'd1,
    WR_WORD = 2'd2,
    WR_RSVD = 2'd3
  } wrMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic [REG_COUNT-1:0] load;      // register captures on this edge
    logic [REG_COUNT-1:0] takeCore;  // source is the core port
    logic [REG_COUNT-1:0] takeHigh;  // core source uses the high byte
    logic [BYTE_W-1:0]    coreLo;
    logic [BYTE_W-1:0]    coreHi;
    logic [BYTE_W-1:0]    dsByte;
    logic                 dsSel;     // data-space address hits the window
  } rfStrobe_t;
endpackage

// File: rtl/regfile_ctrl.sv
module regfile_ctrl
  import regfile_pkg::*;
#(
  parameter int DS_ADDR_W = 16
) (
  input  logic [1:0]           wrMode,
  input  logic [ADDR_W-1:0]    wrAddr,
  input  logic [2*BYTE_W-1:0]  wrData,
  input  logic [DS_ADDR_W-1:0] dsAddr,
  input  logic                 dsWrEn,
  input  logic [BYTE_W-1:0]    dsWrData,
  output rfStrobe_t            strobe
);
  localparam logic [DS_ADDR_W-1:0] WINDOW_TOP = DS_ADDR_W'(REG_COUNT);

  wrMode_e mode;
  logic    inWindow;
  logic    byteWr;
  logic    wordWr;

  assign mode     = wrMode_e'(wrMode);
  assign inWindow = (dsAddr < WINDOW_TOP);
  assign byteWr   = (mode == WR_BYTE);
  assign wordWr   = (mode == WR_WORD);

  assign strobe.coreLo = wrData[BYTE_W-1:0];
  assign strobe.coreHi = wrData[2*BYTE_W-1:BYTE_W];
  assign strobe.dsByte = dsWrData;
  assign strobe.dsSel  = inWindow;

  for (genvar i = 0; i < REG_COUNT; i++) begin : g_dec
    localparam logic [ADDR_W-1:0] IDX = ADDR_W'(i);
    logic coreHit;
    logic dsHitReg;
    assign coreHit  = (byteWr && wrAddr == IDX) ||
                      (wordWr && wrAddr[ADDR_W-1:1] == IDX[ADDR_W-1:1]);
    assign dsHitReg = dsWrEn && inWindow && (dsAddr[ADDR_W-1:0] == IDX);
    assign strobe.load[i]     = coreHit | dsHitReg;
    assign strobe.takeCore[i] = coreHit;
    assign strobe.takeHigh[i] = wordWr && IDX[0];
  end
endmodule

// File: rtl/regfile_dp.sv
module regfile_dp
  import regfile_pkg::*;
#(
  parameter int PTR_BASE  = 26,
  parameter int PTR_COUNT = 3
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  rfStrobe_t                    strobe,
  input  logic [ADDR_W-1:0]            rdAddrA,
  input  logic [ADDR_W-1:0]            rdAddrB,
  input  logic [ADDR_W-1:0]            dsIdx,
  output logic [BYTE_W-1:0]            rdDataA,
  output logic [BYTE_W-1:0]            rdDataB,
  output logic [2*BYTE_W-1:0]          rdWord,
  output logic [BYTE_W-1:0]            dsRdData,
  output logic [PTR_COUNT*2*BYTE_W-1:0] ptrFlat,
  output logic [REG_COUNT*BYTE_W-1:0]  regFlat
);
  logic [BYTE_W-1:0] regs [REG_COUNT];

  for (genvar i = 0; i < REG_COUNT; i++) begin : g_reg
    logic [BYTE_W-1:0] nextVal;
    always_comb begin
      if (strobe.takeCore[i])
        nextVal = strobe.takeHigh[i] ? strobe.coreHi : strobe.coreLo;
      else
        nextVal = strobe.dsByte;
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               regs[i] <= '0;
      else if (strobe.load[i]) regs[i] <= nextVal;
    end
    assign regFlat[i*BYTE_W +: BYTE_W] = regs[i];
  end

  for (genvar p = 0; p < PTR_COUNT; p++) begin : g_ptr
    assign ptrFlat[p*2*BYTE_W +: 2*BYTE_W] =
      {regs[PTR_BASE + 2*p + 1], regs[PTR_BASE + 2*p]};
  end

  assign rdDataA  = regs[rdAddrA];
  assign rdDataB  = regs[rdAddrB];
  assign rdWord   = {regs[{rdAddrA[ADDR_W-1:1], 1'b1}], regs[{rdAddrA[ADDR_W-1:1], 1'b0}]};
  assign dsRdData = strobe.dsSel ? regs[dsIdx] : '0;
endmodule

// File: rtl/gp_regfile.sv
module gp_regfile
  import regfile_pkg::*;
#(
  parameter int DS_ADDR_W = 16,
  parameter int PTR_BASE  = 26
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [4:0]           rdAddrA,
  input  logic [4:0]           rdAddrB,
  output logic [7:0]           rdDataA,
  output logic [7:0]           rdDataB,
  output logic [15:0]          rdWord,
  input  logic [1:0]           wrMode,
  input  logic [4:0]           wrAddr,
  input  logic [15:0]          wrData,
  input  logic [DS_ADDR_W-1:0] dsAddr,
  input  logic                 dsWrEn,
  input  logic [7:0]           dsWrData,
  output logic [7:0]           dsRdData,
  output logic                 dsHit,
  output logic [15:0]          ptrX,
  output logic [15:0]          ptrY,
  output logic [15:0]          ptrZ
);
  localparam int PTR_COUNT = 3;
  localparam int WORD_W    = 2*BYTE_W;

  rfStrobe_t                      strobe;
  logic [PTR_COUNT*WORD_W-1:0]    ptrFlat;
  logic [REG_COUNT*BYTE_W-1:0]    regFlat;

  regfile_ctrl #(.DS_ADDR_W(DS_ADDR_W)) u_ctrl (
    .wrMode  (wrMode),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .dsAddr  (dsAddr),
    .dsWrEn  (dsWrEn),
    .dsWrData(dsWrData),
    .strobe  (strobe)
  );

  regfile_dp #(.PTR_BASE(PTR_BASE), .PTR_COUNT(PTR_COUNT)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .rdAddrA (rdAddrA),
    .rdAddrB (rdAddrB),
    .dsIdx   (dsAddr[ADDR_W-1:0]),
    .rdDataA (rdDataA),
    .rdDataB (rdDataB),
    .rdWord  (rdWord),
    .dsRdData(dsRdData),
    .ptrFlat (ptrFlat),
    .regFlat (regFlat)
  );

  assign dsHit = strobe.dsSel;
  assign ptrX  = ptrFlat[0*WORD_W +: WORD_W];
  assign ptrY  = ptrFlat[1*WORD_W +: WORD_W];
  assign ptrZ  = ptrFlat[2*WORD_W +: WORD_W];

  logic dsInWin;
  assign dsInWin = dsWrEn && (dsAddr < DS_ADDR_W'(REG_COUNT));

  p_reset_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (regFlat == '0));

  p_byte_core_wins_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrMode == 2'd1) |=> (regFlat[BYTE_W*$past(wrAddr) +: BYTE_W] == $past(wrData[7:0])));

  p_word_core_wins_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wrMode == 2'd2) |=> (regFlat[WORD_W*$past(wrAddr[4:1]) +: WORD_W] == $past(wrData)));

  p_ds_store_r8: assert property (@(posedge clk) disable iff (!rstN)
    (dsInWin && wrMode != 2'd1 && wrMode != 2'd2)
      |=> (regFlat[BYTE_W*$past(dsAddr[4:0]) +: BYTE_W] == $past(dsWrData)));

  p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!dsInWin && wrMode != 2'd1 && wrMode != 2'd2) |=> $stable(regFlat));

  p_ptr_word_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddrA[4:1] == 4'd13) |-> (ptrX == rdWord));

  p_ds_miss_r7: assert property (@(posedge clk) disable iff (!rstN)
    !dsHit |-> (dsRdData == 8'h00));
endmodule

// File: tb/gp_regfile_tb.sv
module gp_regfile_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  rdAddrA = '0, rdAddrB = '0;
  logic [7:0]  rdDataA, rdDataB;
  logic [15:0] rdWord;
  logic [1:0]  wrMode = '0;
  logic [4:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] dsAddr = 16'hFFFF;
  logic        dsWrEn = 1'b0;
  logic [7:0]  dsWrData = '0;
  logic [7:0]  dsRdData;
  logic        dsHit;
  logic [15:0] ptrX, ptrY, ptrZ;

  int errors = 0;
  int checks = 0;
  logic [7:0] model [32];
  bit done = 0;

  always #5 clk = ~clk;

  gp_regfile u_dut (.*);

  task automatic check(string req, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
    wrMode = 2'd0; dsWrEn = 1'b0; dsAddr = 16'hFFFF;
  endtask

  task automatic coreWr(logic [1:0] m, logic [4:0] a, logic [15:0] d);
    @(negedge clk);
    wrMode = m; wrAddr = a; wrData = d;
    tick();
  endtask

  task automatic dsWr(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    dsAddr = a; dsWrEn = 1'b1; dsWrData = d;
    tick();
  endtask

  // full sweep of every read path against the model
  task automatic sweep(string req);
    for (int i = 0; i < 32; i++) begin
      rdAddrA = 5'(i); rdAddrB = 5'(31 - i); dsAddr = 16'(i);
      #1;
      check({req, " R2 portA"}, rdDataA, model[i]);
      check({req, " R2 portB"}, rdDataB, model[31 - i]);
      check({req, " R7 dsRead"}, dsRdData, model[i]);
      check({req, " R7 dsHit"}, dsHit, 1);
      check({req, " R5 word"}, rdWord, {model[i | 1], model[i & 30]});
    end
    check({req, " R6 ptrX"}, ptrX, {model[27], model[26]});
    check({req, " R6 ptrY"}, ptrY, {model[29], model[28]});
    check({req, " R6 ptrZ"}, ptrZ, {model[31], model[30]});
    dsAddr = 16'hFFFF;
  endtask

  initial begin
    for (int i = 0; i < 32; i++) model[i] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    #1;
    sweep("R1 reset");

    // R3: byte writes to every register
    for (int i = 0; i < 32; i++) begin
      model[i] = 8'((i * 7 + 3) & 255);
      coreWr(2'd1, 5'(i), {8'hEE, model[i]});
    end
    sweep("R3 byte");

    // R4: word writes, odd address aligns down
    for (int k = 0; k < 16; k++) begin
      logic [15:0] w;
      w = 16'((k * 16'h1357 + 16'h0A0B) & 16'hFFFF);
      model[2*k] = w[7:0]; model[2*k + 1] = w[15:8];
      coreWr(2'd2, 5'(2*k + (k % 2)), w);
    end
    sweep("R4 word");

    // R4: modes 0 and 3 write nothing
    coreWr(2'd3, 5'd4, 16'hDEAD);
    coreWr(2'd0, 5'd5, 16'hBEEF);
    sweep("R4 nowrite");

    // R8: data-space writes through the window
    for (int i = 0; i < 32; i++) begin
      model[i] = 8'((255 - i * 5) & 255);
      dsWr(16'(i), model[i]);
    end
    sweep("R8 dsWrite");

    // R8/R7: outside the window
    dsWr(16'h0020, 8'h55);
    dsWr(16'h1234, 8'hAA);
    dsWr(16'hFFE0, 8'h77);
    sweep("R8 outside");
    dsAddr = 16'h0020; #1;
    check("R7 miss hit", dsHit, 0);
    check("R7 miss data", dsRdData, 0);
    dsAddr = 16'h8003; #1;
    check("R7 miss high data", dsRdData, 0);

    // R2: no bypass during a write cycle
    @(negedge clk);
    wrMode = 2'd1; wrAddr = 5'd9; wrData = 16'h00C3;
    rdAddrA = 5'd9; #1;
    check("R2 no bypass", rdDataA, model[9]);
    tick(); model[9] = 8'hC3;
    rdAddrA = 5'd9; #1;
    check("R2 after write", rdDataA, 8'hC3);

    // R9: same register, byte
    @(negedge clk);
    wrMode = 2'd1; wrAddr = 5'd12; wrData = 16'h0011;
    dsAddr = 16'd12; dsWrEn = 1'b1; dsWrData = 8'h99;
    tick(); model[12] = 8'h11;
    // R9: word high byte vs data-space
    @(negedge clk);
    wrMode = 2'd2; wrAddr = 5'd30; wrData = 16'h4321;
    dsAddr = 16'd31; dsWrEn = 1'b1; dsWrData = 8'h66;
    tick(); model[30] = 8'h21; model[31] = 8'h43;
    // R9: different registers both land
    @(negedge clk);
    wrMode = 2'd2; wrAddr = 5'd26; wrData = 16'hBEAD;
    dsAddr = 16'd3; dsWrEn = 1'b1; dsWrData = 8'h3C;
    tick(); model[26] = 8'hAD; model[27] = 8'hBE; model[3] = 8'h3C;
    sweep("R9 collide");
    check("R9 ptrZ", ptrZ, 16'h4321);
    check("R9 ptrX", ptrX, 16'hBEAD);

    // R1: reset again clears everything
    @(negedge clk); rstN = 1'b0; #1;
    for (int i = 0; i < 32; i++) model[i] = 8'h00;
    @(negedge clk); rstN = 1'b1; #1;
    sweep("R1 rereset");

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule